// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns an effective-segment request into a scattered 36-bit segment identifier. A request is either kernel or user. A kernel request uses the 36-bit effective segment number directly as the pre-scramble value. A user request joins a 20-bit context number above the low 15 bits of the segment number. The pre-scramble value is then multiplied by the fixed prime 200730139 and reduced modulo 2^36-1. No divider is used. The product is folded by adding its upper bits to its lower 36 bits, and an end-around carry step finishes the reduction.

The block is a fixed-latency pipeline that accepts one request per cycle. Both edges use valid/ready. An input is taken on a clock edge where `req_valid` and `req_ready` are both high. A result held on the output with `rsp_ready` low stays unchanged until it is taken. The whole pipeline advances only when the output register is empty or is being consumed. `req_ready` follows that condition, so back-pressure reaches the input in the same cycle. A bubble inside the pipeline is not squeezed out during a stall. Pre-scramble values in the reserved ranges are still scrambled, but their result carries an error flag.

Top module: `seg_id_scrambler`

## Requirements
- R1: For every accepted request, `rsp_id` equals (P × 200730139) mod (2^36 − 1), where P is the pre-scramble value.
- R2: For a user request (`req_kernel`=0), P = {`req_ctx`[19:0], `req_esid`[14:0]}, which is 35 bits and zero-extended to 36. Segment bits 35:15 are ignored.
- R3: For a kernel request (`req_kernel`=1), P equals `req_esid` and `req_ctx` is ignored.
- R4: `rsp_err` is 1 exactly when P[35:34] = 2'b10 or P = 36'hFFFFFFFFF. It is 0 otherwise, and it is 0 whenever `rsp_valid` is 0.
- R5: P = 36'hFFFFFFFFF gives `rsp_id` = 0. `rsp_id` never equals 36'hFFFFFFFFF while valid.
- R6: While `rsp_valid`=1 and `rsp_ready`=0, the next cycle still has `rsp_valid`=1 with `rsp_id` and `rsp_err` unchanged.
- R7: `req_ready` is 1 whenever `rsp_valid` is 0 or `rsp_ready` is 1. Results leave in the order the requests were accepted, at up to one per cycle.
- R8: With no stall, a request accepted at clock edge t gives `rsp_valid`=1 after edge t+3, and not earlier.
- R9: While `rst_n` is low, and after its release until a request flows through, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when also valid |
| req_kernel | input | 1 | 1 = kernel request, 0 = user request |
| req_ctx | input | 20 | Context number for user requests |
| req_esid | input | 36 | Effective segment number |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result on this edge |
| rsp_id | output | 36 | Scrambled identifier |
| rsp_err | output | 1 | Pre-scramble value was in a reserved range |

## Verification
There are four register stages between input and output. A result therefore appears three edges after the accepting edge when nothing stalls. A dedicated isolated request checks that `rsp_valid` is still low two edges after acceptance and high one edge later. In all other tests the scoreboard does not rely on timing. The driver queues each expected identifier at its accepting edge, and the monitor compares a result only at an edge where it is actually consumed. All handshake signals are sampled just before the rising edge. During stalls the monitor also checks that a held result has not changed one cycle later.

// File: rtl/seg_scr_pkg.sv
package seg_scr_pkg;
  localparam int unsigned ID_W      = 36;
  localparam int unsigned CTX_W     = 20;
  localparam int unsigned USR_SEG_W = 15;
  localparam int unsigned MULT_W    = 28;
  localparam int unsigned MULT_VAL  = 200730139;
  localparam int unsigned PROD_W    = ID_W + MULT_W;

  typedef logic [ID_W-1:0] id_t;

  typedef struct packed {
    logic valid;
    logic err;
    id_t  proto;
  } proto_beat_t;
endpackage

// File: rtl/seg_proto_former.sv
module seg_proto_former
  import seg_scr_pkg::*;
#(
  parameter int unsigned IDW  = ID_W,
  parameter int unsigned CW   = CTX_W,
  parameter int unsigned USW  = USR_SEG_W
) (
  input  logic           kernel,
  input  logic [CW-1:0]  ctx,
  input  logic [IDW-1:0] esid,
  output logic [IDW-1:0] proto,
  output logic           reserved
);
  localparam int unsigned PAD_W = IDW - CW - USW;

  logic [IDW-1:0] user_proto;

  generate
    if (PAD_W > 0) begin : g_pad
      assign user_proto = {{PAD_W{1'b0}}, ctx, esid[USW-1:0]};
    end else begin : g_nopad
      assign user_proto = {ctx, esid[USW-1:0]};
    end
  endgenerate

  always_comb begin
    proto    = kernel ? esid : user_proto;
    reserved = (proto[IDW-1:IDW-2] == 2'b10) || (&proto);
  end
endmodule

// File: rtl/seg_mulmod_pipe.sv
module seg_mulmod_pipe
  import seg_scr_pkg::*;
#(
  parameter int unsigned IDW   = ID_W,
  parameter int unsigned MW    = MULT_W,
  parameter int unsigned MVAL  = MULT_VAL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_v,
  input  logic           in_err,
  input  logic [IDW-1:0] in_proto,
  output logic           out_v,
  output logic           out_err,
  output logic [IDW-1:0] out_id
);
  localparam int unsigned PW = IDW + MW;
  localparam logic [MW-1:0] MCONST = MW'(MVAL);

  // stage A: full product
  logic          a_v, a_err;
  logic [PW-1:0] a_prod;
  // stage B: folded sum (fits in IDW+1 bits since MW < IDW)
  logic          b_v, b_err;
  logic [IDW:0]  b_fold;
  // end-around correction (combinational into stage C)
  logic [IDW:0]   fold_plus1;
  logic [IDW-1:0] corrected;

  always_comb begin
    fold_plus1 = b_fold + (IDW+1)'(1);
    corrected  = b_fold[IDW-1:0] + IDW'(fold_plus1[IDW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v <= 1'b0; a_err <= 1'b0; a_prod <= '0;
      b_v <= 1'b0; b_err <= 1'b0; b_fold <= '0;
      out_v <= 1'b0; out_err <= 1'b0; out_id <= '0;
    end else if (en) begin
      a_v    <= in_v;
      a_err  <= in_v & in_err;
      a_prod <= {{MW{1'b0}}, in_proto} * {{IDW{1'b0}}, MCONST};
      b_v    <= a_v;
      b_err  <= a_v & a_err;
      b_fold <= {1'b0, a_prod[IDW-1:0]} + (IDW+1)'(a_prod[PW-1:IDW]);
      out_v   <= b_v;
      out_err <= b_v & b_err;
      out_id  <= corrected;
    end
  end

  // R1: folded sum stays below 2^IDW + 2^MW, so one correction step suffices
  a_r1_fold_range: assert property (@(posedge clk) disable iff (!rst_n)
    b_v |-> (b_fold < ((IDW+1)'(1) << IDW) + ((IDW+1)'(1) << MW)));
  // R5: the reserved all-ones value never leaves the pipeline
  a_r5_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> !(&out_id));
endmodule

// File: rtl/seg_id_scrambler.sv
module seg_id_scrambler
  import seg_scr_pkg::*;
#(
  parameter int unsigned IDW  = ID_W,
  parameter int unsigned CW   = CTX_W,
  parameter int unsigned USW  = USR_SEG_W,
  parameter int unsigned MW   = MULT_W,
  parameter int unsigned MVAL = MULT_VAL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_kernel,
  input  logic [CW-1:0]  req_ctx,
  input  logic [IDW-1:0] req_esid,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [IDW-1:0] rsp_id,
  output logic           rsp_err
);
  logic           advance;
  logic [IDW-1:0] f_proto;
  logic           f_res;
  logic           s0_v, s0_err;
  logic [IDW-1:0] s0_proto;

  seg_proto_former #(.IDW(IDW), .CW(CW), .USW(USW)) u_form (
    .kernel   (req_kernel),
    .ctx      (req_ctx),
    .esid     (req_esid),
    .proto    (f_proto),
    .reserved (f_res)
  );

  assign advance   = !rsp_valid || rsp_ready;
  assign req_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_v <= 1'b0; s0_err <= 1'b0; s0_proto <= '0;
    end else if (advance) begin
      s0_v     <= req_valid;
      s0_err   <= req_valid & f_res;
      s0_proto <= f_proto;
    end
  end

  seg_mulmod_pipe #(.IDW(IDW), .MW(MW), .MVAL(MVAL)) u_mm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (advance),
    .in_v     (s0_v),
    .in_err   (s0_err),
    .in_proto (s0_proto),
    .out_v    (rsp_valid),
    .out_err  (rsp_err),
    .out_id   (rsp_id)
  );

  // R6: stalled result is held
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_err)));
  // R7: an empty output never blocks the input
  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  // R4: error flag only accompanies a valid result
  a_r4_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  // R4: a user request can never be reserved
  a_r4_user_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel) |-> !f_res);
endmodule

// File: tb/seg_id_scrambler_bench.sv
module seg_id_scrambler_bench;
  localparam longint unsigned MOD = 64'hF_FFFF_FFFF;
  localparam longint unsigned MUL = 64'd200730139;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_kernel = 1'b0, rsp_ready = 1'b1;
  logic [19:0] req_ctx = '0;
  logic [35:0] req_esid = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [35:0] rsp_id;

  int errors = 0, checks = 0;
  bit done = 1'b0, mon_on = 1'b0, rdy_rand = 1'b0;
  logic [36:0] exp_q[$];

  always #5 clk = ~clk;

  seg_id_scrambler u_seg_id_scrambler (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kernel(req_kernel), .req_ctx(req_ctx), .req_esid(req_esid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [36:0] model(input bit k, input logic [19:0] c, input logic [35:0] e);
    longint unsigned p, r;
    bit bad;
    p = k ? longint'(e) : ((longint'(c) << 15) | longint'(e[14:0]));
    r = (p * MUL) % MOD;
    bad = (p[35:34] == 2'b10) || (p == MOD);
    return {bad, r[35:0]};
  endfunction

  task automatic send(input bit k, input logic [19:0] c, input logic [35:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_kernel = k; req_ctx = c; req_esid = e;
    #4;
    while (!req_ready) begin @(negedge clk); #4; end
    @(posedge clk);
    exp_q.push_back(model(k, c, e));
    #1 req_valid = 1'b0;
  endtask

  // consumer back-pressure
  always @(negedge clk) if (rdy_rand) rsp_ready <= ($urandom_range(0, 3) != 0);

  // monitor / scoreboard
  logic        held_v = 1'b0, held_err;
  logic [35:0] held_id;
  always @(negedge clk) begin
    #4;
    if (mon_on) begin
      if (held_v) begin
        // R6: held result unchanged
        check(rsp_valid && rsp_id == held_id && rsp_err == held_err, "R6",
              {27'd0, rsp_valid, rsp_id}, {27'd0, 1'b1, held_id});
      end
      held_v = rsp_valid && !rsp_ready;
      held_id = rsp_id; held_err = rsp_err;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected result", {28'd0, rsp_id}, 64'd0);
        else begin
          logic [36:0] e;
          e = exp_q.pop_front();
          check(rsp_id == e[35:0], "R1", {28'd0, rsp_id}, {28'd0, e[35:0]});
          check(rsp_err == e[36], "R4", {63'd0, rsp_err}, {63'd0, e[36]});
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(rsp_valid == 1'b0, "R9 valid in reset", {63'd0, rsp_valid}, 64'd0);
    check(req_ready == 1'b1, "R9 ready in reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 valid after release", {63'd0, rsp_valid}, 64'd0);
    mon_on = 1'b1;

    // R8: latency of an isolated request
    send(1'b1, 20'd0, 36'hC_0000_0001);
    repeat (2) @(posedge clk);
    #1 check(rsp_valid == 1'b0, "R8 early", {63'd0, rsp_valid}, 64'd0);
    @(posedge clk);
    #1 check(rsp_valid == 1'b1, "R8 due", {63'd0, rsp_valid}, 64'd1);
    repeat (3) @(negedge clk);

    // boundary cases
    send(1'b1, 20'hABCDE, 36'hF_FFFF_FFFF);  // R5 all ones -> 0, err; R3 ctx ignored
    send(1'b1, 20'd0, 36'h8_0000_0000);      // R4 reserved 10 prefix
    send(1'b1, 20'd0, 36'hB_FFFF_FFFF);      // R4 reserved top of 10 range
    send(1'b1, 20'd0, 36'hF_FFFF_FFFE);      // R3 largest legal kernel
    send(1'b1, 20'd0, 36'hC_0000_0000);      // R3 lowest kernel
    send(1'b0, 20'd0, 36'd0);                // R2 zero
    send(1'b0, 20'hFFFFF, 36'hF_FFFF_FFFF);  // R2 upper esid bits ignored, no err
    send(1'b0, 20'h12345, 36'h0_0000_7FFF);
    send(1'b0, 20'h00001, 36'hA_AAAA_8000);  // R2 bit 15 of esid ignored
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 64'd0);

    // random traffic with back-pressure (R6, R7)
    rdy_rand = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [35:0] e;
      bit k;
      k = $urandom_range(0, 1) == 1;
      e = {$urandom(), $urandom()} ;
      if (k && (i % 3 != 0)) e[35:34] = 2'b11;
      send(k, 20'($urandom()), e);
    end
    rdy_rand = 1'b0;
    @(negedge clk) rsp_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results returned", exp_q.size(), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule